// File: doc/BRIEF.md
# Timestamp Ring Buffer Readout

This block gathers tagged timestamps into a small circular store. Each timestamp comes with a source number, a seconds value, a 28-bit cycle count and a 12-bit fraction. A timestamp is accepted only while collection is switched on and the mask bit for its source is set. The block attaches a 16-bit sequence number to every accepted timestamp and keeps it with the entry.

A host works through a register window with a single-cycle write strobe and a combinational read. It first checks the empty flag in the control/status word. It then writes the advance register, which copies the oldest stored entry into a set of readout registers. Last, it reads seconds (upper and lower words), cycles and a packed tag word. The same control word holds the enable, the per-source mask and two action bits: one discards everything stored, the other restarts the sequence numbering. When the store is full, a new timestamp replaces the oldest one and a sticky overflow flag is set.

Top module: `tsrb_readout`

## Requirements
- R1: After reset the control/status word reads 0x00000002: enable off, mask zero, empty set, overflow clear. The seconds-high (addr 2), seconds-low (addr 3), cycles (addr 4) and tag (addr 5) readout registers all read zero.
- R2: A timestamp with `ts_valid` high is stored only when enable (CSR bit 0) is set and its source `s` is below NSRC with mask bit `s` set. The mask sits at CSR bits [8+NSRC-1:8]. In every other case nothing is stored.
- R3: A write to address 1 (advance) with the store non-empty copies the oldest entry into the readout registers, in arrival order. Seconds split into a high word at addr 2 (seconds bits above 31) and a low word at addr 3 (bits 31:0). Cycles read at addr 4, zero-extended from 28 bits.
- R4: The tag word at addr 5 holds the source in bits [2:0], zero in bit 3, the fraction in bits [15:4] and the sequence number in bits [31:16].
- R5: Every stored timestamp takes the current sequence number, and the number then increments by one. It wraps from 0xFFFF to 0. Rejected timestamps do not consume a number.
- R6: A CSR write with bit 2 set restarts numbering, so the next stored timestamp gets sequence 0.
- R7: A CSR write with bit 1 set empties the store in that cycle: empty (CSR read bit 1) is set and overflow (CSR read bit 2) is cleared. An advance afterwards leaves the readout registers unchanged.
- R8: A timestamp stored while DEPTH entries are held overwrites the oldest entry and sets the sticky overflow flag (CSR read bit 2).
- R9: An advance written while the store is empty leaves all readout registers unchanged.
- R10: The empty flag is clear exactly while at least one entry is held. It clears on the edge that stores the first entry and sets again on the advance that removes the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | A timestamp is presented this cycle |
| ts_src | input | 3 | Source number of the timestamp |
| ts_sec | input | SEC_W | Seconds value |
| ts_cyc | input | CYC_W | Cycle count |
| ts_frac | input | 12 | Fractional part |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
The hardest state to reach from the ports is the 16-bit sequence rollover. It occurs at the same moment as a store that is overflowing, so the entries that survive straddle the wrap. The stimulus first restarts numbering. It then holds `ts_valid` high for 65537 consecutive cycles, which numbers the final eight survivors 65529 through 65535 and then 0. It drains them one by one and checks each tag word. Overwrite order is checked the same way on a shorter run: the first entry drained after ten stores into eight slots must be the third one written.

// File: rtl/tsrb_pkg.sv
package tsrb_pkg;
   localparam int SRC_W  = 3;
   localparam int FRAC_W = 12;
   localparam int SEQ_W  = 16;

   // register window addresses
   typedef enum logic [2:0] {
      RA_CSR  = 3'd0,
      RA_ADV  = 3'd1,
      RA_SECH = 3'd2,
      RA_SECL = 3'd3,
      RA_CYC  = 3'd4,
      RA_TAG  = 3'd5
   } reg_addr_e;

   // control/status bit positions
   localparam int CSR_EN    = 0;
   localparam int CSR_PURGE = 1;  // write: action
   localparam int CSR_EMPTY = 1;  // read: status
   localparam int CSR_SQRST = 2;  // write: action
   localparam int CSR_OVF   = 2;  // read: status
   localparam int CSR_MASK  = 8;
endpackage

// File: rtl/tsrb_admit.sv
module tsrb_admit
   import tsrb_pkg::*;
#(
   parameter int NSRC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ts_valid,
   input  logic [SRC_W-1:0]  ts_src,
   input  logic              enable,
   input  logic [NSRC-1:0]   mask,
   input  logic              seq_clr,
   input  logic              drop,
   output logic              store,
   output logic [SEQ_W-1:0]  seq_tag
);
   logic             src_ok;
   logic [SEQ_W-1:0] seq_q, seq_base;

   always_comb begin
      src_ok = 1'b0;
      for (int i = 0; i < NSRC; i++)
         if (ts_src == SRC_W'(i)) src_ok = mask[i];
   end

   assign store    = ts_valid && enable && src_ok && !drop;
   assign seq_base = seq_clr ? '0 : seq_q;
   assign seq_tag  = seq_base;

   always_ff @(posedge clk) begin
      if (!rst_n)     seq_q <= '0;
      else if (store) seq_q <= seq_base + 1'b1;
      else            seq_q <= seq_base;
   end

   a_r5_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (store && !seq_clr) |=> (seq_q == $past(seq_q) + 1'b1));
   a_r6_seq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_clr && !store) |=> (seq_q == '0));
   a_r2_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_valid && !enable) |-> !store);
endmodule

// File: rtl/tsrb_ring.sv
module tsrb_ring #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   input  logic         purge,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full,
   output logic         overflow
);
   localparam int AW    = $clog2(DEPTH);
   localparam int CNT_W = AW + 1;

   logic [W-1:0]     mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             pop_eff, drop_old;

   assign empty    = (count == '0);
   assign full     = (count == CNT_W'(DEPTH));
   assign head     = mem[rd_ptr];
   assign pop_eff  = pop && !empty && !purge;
   assign drop_old = push && full && !pop_eff;

   always_ff @(posedge clk)
      if (push) mem[wr_ptr] <= din;

   always_ff @(posedge clk) begin
      if (!rst_n || purge) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop_eff || drop_old) rd_ptr <= rd_ptr + 1'b1;
         if (push && !pop_eff && !full) count <= count + 1'b1;
         else if (!push && pop_eff)     count <= count - 1'b1;
         if (drop_old) overflow <= 1'b1;
      end
   end

   a_r7_purge_empty: assert property (@(posedge clk) disable iff (!rst_n)
      purge |=> (empty && !overflow));
   a_r8_overwrite_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !purge) |=> (overflow && full));
   a_r10_pop_last: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !purge && (count == CNT_W'(1))) |=> empty);
endmodule

// File: rtl/tsrb_readout.sv
module tsrb_readout
   import tsrb_pkg::*;
#(
   parameter int NSRC  = 2,
   parameter int DEPTH = 8,
   parameter int SEC_W = 40,
   parameter int CYC_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ts_valid,
   input  logic [2:0]        ts_src,
   input  logic [SEC_W-1:0]  ts_sec,
   input  logic [CYC_W-1:0]  ts_cyc,
   input  logic [11:0]       ts_frac,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   localparam int ENT_W = SEC_W + CYC_W + FRAC_W + SEQ_W + SRC_W;

   // elaboration-time parameter checks
   if (NSRC < 1 || NSRC > 8) begin : g_bad_nsrc
      $error("NSRC must be 1..8");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (SEC_W < 1 || SEC_W > 64) begin : g_bad_sec
      $error("SEC_W must be 1..64");
   end
   if (CYC_W < 1 || CYC_W > 32) begin : g_bad_cyc
      $error("CYC_W must be 1..32");
   end

   logic             enable_q;
   logic [NSRC-1:0]  mask_q;
   logic             wr_csr, wr_adv, purge, seq_clr;
   logic             store, empty, full, overflow;
   logic [SEQ_W-1:0] seq_tag;
   logic [ENT_W-1:0] ent_in, ent_head;

   logic [SEC_W-1:0] rd_sec_q;
   logic [CYC_W-1:0] rd_cyc_q;
   logic [FRAC_W-1:0] rd_frac_q;
   logic [SEQ_W-1:0] rd_seq_q;
   logic [SRC_W-1:0] rd_src_q;
   logic [31:0]      sec_hi, sec_lo, csr_rd;
   logic             unused_wbits;

   assign unused_wbits = ^reg_wdata;

   assign wr_csr  = reg_wr && (reg_addr == RA_CSR);
   assign wr_adv  = reg_wr && (reg_addr == RA_ADV);
   assign purge   = wr_csr && reg_wdata[CSR_PURGE];
   assign seq_clr = wr_csr && reg_wdata[CSR_SQRST];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= 1'b0;
         mask_q   <= '0;
      end else if (wr_csr) begin
         enable_q <= reg_wdata[CSR_EN];
         mask_q   <= reg_wdata[CSR_MASK +: NSRC];
      end
   end

   tsrb_admit #(.NSRC(NSRC)) i_admit (
      .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_src(ts_src),
      .enable(enable_q), .mask(mask_q), .seq_clr(seq_clr), .drop(purge),
      .store(store), .seq_tag(seq_tag)
   );

   assign ent_in = {ts_sec, ts_cyc, ts_frac, seq_tag, ts_src};

   tsrb_ring #(.W(ENT_W), .DEPTH(DEPTH)) i_ring (
      .clk(clk), .rst_n(rst_n), .push(store), .din(ent_in), .pop(wr_adv),
      .purge(purge), .head(ent_head), .empty(empty), .full(full),
      .overflow(overflow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_sec_q  <= '0;
         rd_cyc_q  <= '0;
         rd_frac_q <= '0;
         rd_seq_q  <= '0;
         rd_src_q  <= '0;
      end else if (wr_adv && !empty) begin
         {rd_sec_q, rd_cyc_q, rd_frac_q, rd_seq_q, rd_src_q} <= ent_head;
      end
   end

   if (SEC_W > 32) begin : g_sec_wide
      assign sec_hi = 32'(rd_sec_q[SEC_W-1:32]);
      assign sec_lo = rd_sec_q[31:0];
   end else begin : g_sec_narrow
      assign sec_hi = '0;
      assign sec_lo = 32'(rd_sec_q);
   end

   always_comb begin
      csr_rd = '0;
      csr_rd[CSR_EN]    = enable_q;
      csr_rd[CSR_EMPTY] = empty;
      csr_rd[CSR_OVF]   = overflow;
      csr_rd[CSR_MASK +: NSRC] = mask_q;
   end

   always_comb begin
      case (reg_addr)
         RA_CSR:  reg_rdata = csr_rd;
         RA_SECH: reg_rdata = sec_hi;
         RA_SECL: reg_rdata = sec_lo;
         RA_CYC:  reg_rdata = 32'(rd_cyc_q);
         RA_TAG:  reg_rdata = {rd_seq_q, rd_frac_q, 1'b0, rd_src_q};
         default: reg_rdata = '0;
      endcase
   end

   a_r9_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_adv && empty) |=> ($stable(rd_cyc_q) && $stable(rd_seq_q) && $stable(rd_sec_q)));
   a_r10_store_fills: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> !empty);
   a_r3_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !wr_adv && !purge) |=> full);
endmodule

// File: tb/test_tsrb_readout.sv
`timescale 1ns/1ps
module test_tsrb_readout;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ts_valid = 1'b0;
   logic [2:0]  ts_src = '0;
   logic [39:0] ts_sec = '0;
   logic [27:0] ts_cyc = '0;
   logic [11:0] ts_frac = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int seq_exp = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tsrb_readout #(.NSRC(2), .DEPTH(DEPTH), .SEC_W(40), .CYC_W(28)) i_tsrb_readout (
      .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_src(ts_src),
      .ts_sec(ts_sec), .ts_cyc(ts_cyc), .ts_frac(ts_frac), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   typedef struct packed {
      logic [2:0]  src;
      logic [39:0] sec;
      logic [27:0] cyc;
      logic [11:0] frac;
      logic        kept;
   } vec_t;

   // mask = 3 (sources 0 and 1); sources 2 and 5 are beyond NSRC
   localparam vec_t VECS [8] = '{
      '{3'd0, 40'h12_3456_789A, 28'hABC_DEF1, 12'h123, 1'b1},
      '{3'd1, 40'hFF_FFFF_FFFF, 28'hFFF_FFFF, 12'hFFF, 1'b1},
      '{3'd2, 40'h01_0000_0000, 28'h000_0010, 12'h001, 1'b0},
      '{3'd1, 40'h00_0000_0001, 28'h000_0000, 12'h000, 1'b1},
      '{3'd0, 40'hA5_5A5A_A5A5, 28'h555_5555, 12'hAAA, 1'b1},
      '{3'd5, 40'h33_3333_3333, 28'h333_3333, 12'h333, 1'b0},
      '{3'd0, 40'h80_0000_0000, 28'h800_0000, 12'h800, 1'b1},
      '{3'd1, 40'h00_8000_0000, 28'h000_0001, 12'h7FF, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic push(input logic [2:0] s, input logic [39:0] sec,
                       input logic [27:0] cyc, input logic [11:0] fr);
      @(negedge clk);
      ts_src = s; ts_sec = sec; ts_cyc = cyc; ts_frac = fr; ts_valid = 1'b1;
      @(negedge clk);
      ts_valid = 1'b0;
   endtask

   task automatic read_out(input string req, input logic [39:0] sec,
                           input logic [27:0] cyc, input logic [11:0] fr,
                           input logic [15:0] sq, input logic [2:0] s);
      logic [31:0] d;
      rd(3'd2, d); chk({req, " R3 sec_hi"}, d, {24'h0, sec[39:32]});
      rd(3'd3, d); chk({req, " R3 sec_lo"}, d, sec[31:0]);
      rd(3'd4, d); chk({req, " R3 cycles"}, d, {4'h0, cyc});
      rd(3'd5, d); chk({req, " R4 tag"}, d, {sq, fr, 1'b0, s});
   endtask

   task automatic pop_check(input string req, input logic [39:0] sec,
                            input logic [27:0] cyc, input logic [11:0] fr,
                            input logic [15:0] sq, input logic [2:0] s);
      wr(3'd1, 32'h0);
      read_out(req, sec, cyc, fr, sq, s);
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, d); chk("R1 csr", d, 32'h2);
      read_out("R1", 40'h0, 28'h0, 12'h0, 16'h0, 3'd0);

      // R2 disabled: nothing stored; R9 advance on empty keeps readout
      push(3'd0, 40'h1, 28'h1, 12'h1);
      rd(3'd0, d); chk("R2 disabled empty", d, 32'h2);
      wr(3'd1, 0);
      rd(3'd5, d); chk("R9 empty advance", d, 32'h0);

      // table walk: enable, mask = 3
      wr(3'd0, 32'h301);
      for (int i = 0; i < 8; i++)
         push(VECS[i].src, VECS[i].sec, VECS[i].cyc, VECS[i].frac);
      rd(3'd0, d); chk("R10 non-empty", d, 32'h301);
      for (int i = 0; i < 8; i++) begin
         if (VECS[i].kept) begin
            pop_check("R2 table", VECS[i].sec, VECS[i].cyc, VECS[i].frac,
                      16'(seq_exp), VECS[i].src);
            seq_exp++;
         end
      end
      rd(3'd0, d); chk("R10 drained empty", d, 32'h303);

      // R9 advance on empty leaves last entry visible
      wr(3'd1, 0);
      read_out("R9", VECS[7].sec, VECS[7].cyc, VECS[7].frac, 16'd5, 3'd1);

      // R2 mask: only source 0 admitted; R5 rejected takes no number
      wr(3'd0, 32'h101);
      push(3'd1, 40'h7, 28'h7, 12'h7);
      rd(3'd0, d); chk("R2 masked src empty", d, 32'h103);
      push(3'd0, 40'h9, 28'h9, 12'h9);
      pop_check("R5 continue", 40'h9, 28'h9, 12'h9, 16'd6, 3'd0);

      // R6 sequence restart
      wr(3'd0, 32'h105);
      push(3'd0, 40'h2A, 28'h2B, 12'h2C);
      pop_check("R6 restart", 40'h2A, 28'h2B, 12'h2C, 16'd0, 3'd0);

      // R8 overwrite oldest: 10 stores into 8 slots, seq 1..10
      for (int i = 0; i < DEPTH + 2; i++)
         push(3'd0, 40'(i), 28'(i), 12'(i));
      rd(3'd0, d); chk("R8 overflow flag", d, 32'h105);
      pop_check("R8 oldest survivor", 40'd2, 28'd2, 12'd2, 16'd3, 3'd0);

      // R7 purge
      wr(3'd0, 32'h103);
      rd(3'd0, d); chk("R7 purged", d, 32'h103);
      wr(3'd1, 0);
      read_out("R7 after purge", 40'd2, 28'd2, 12'd2, 16'd3, 3'd0);

      // R5 wrap: 65537 back-to-back stores after restart
      wr(3'd0, 32'h105);
      @(negedge clk);
      ts_src = 3'd0; ts_sec = 40'h55; ts_cyc = 28'h66; ts_frac = 12'h77; ts_valid = 1'b1;
      repeat (65537) @(negedge clk);
      ts_valid = 1'b0;
      for (int k = 0; k < DEPTH; k++)
         pop_check("R5 wrap", 40'h55, 28'h66, 12'h77, 16'((k + 65529) % 65536), 3'd0);
      rd(3'd0, d); chk("R10 empty after wrap drain", d, 32'h107);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule